// File: doc/BRIEF.md
# I2C Target Word-Register Bridge

This block sits on an open-drain two-wire bus as a target device and gives a bus master access to a small bank of 16-bit words held inside the block. Every access uses a fixed framing. The master first addresses the block for writing and sends five data bytes: an opcode, a word index, the upper half of a value, the lower half of a value and one pad byte that carries no meaning. When the fifth byte arrives, the frame is carried out. A write opcode stores the value. A read opcode captures the indexed word into a reply holder.

To fetch the reply, the master issues a repeated START, addresses the block for reading and clocks out three bytes: the captured word's upper byte, its lower byte and then a constant filler of 0xFF. The block only ever pulls SDA low and never holds SCL. It oversamples both lines with its own clock, which must run at least 16 times the bus bit rate. Every START and every STOP clears the byte sequencing, so an aborted or short transfer cannot shift the meaning of bytes in later frames. A side read port lets the surrounding logic inspect any stored word. Two status flags show whether a transaction is open and whether this block was selected in it.

Top module: `i2c_word_bridge`

## Requirements
- R1: After reset, sda_oe, bus_busy and selected are 0 and every word of the bank reads 0x0000 on the side port.
- R2: bus_busy goes to 1 after a START (SDA falling while SCL is high) and to 0 after a STOP (SDA rising while SCL is high). A STOP also releases SDA and clears selected.
- R3: When the address byte carries the 7-bit address TGT_ADDR (default 0x42) in bits 7..1, the block pulls SDA low in the ninth clock. Bit 0 of that byte is 1 for a read and 0 for a write. Any other address gets no acknowledge, leaves selected at 0, and the rest of that transaction neither drives SDA nor changes the bank.
- R4: Every data byte received while the block is selected for writing is acknowledged.
- R5: A frame whose first byte is 0x00 writes the value (byte 2 << 8) | byte 3 into the word chosen by byte 1 once the fifth byte is received. The new value is visible on the side port afterwards.
- R6: A frame whose first byte is 0x80 captures the chosen word. The read phase that follows returns its upper byte, then its lower byte, then 0xFF, each sent MSB first. A write frame does not change the captured word.
- R7: Any other opcode leaves the bank unchanged and leaves the captured word as it was, so the next read phase returns the previously captured word.
- R8: Only the low log2(DEPTH) bits of the word-index byte select the word (with DEPTH=16, index 0x13 selects word 3).
- R9: The received byte count restarts at every START and STOP. A frame cut short by a repeated START or by a STOP performs no access, and the next complete frame is decoded from its own first byte.
- R10: If the master does not acknowledge a transmitted byte, the block stops driving SDA until the next START. Further clocks read back 0xFF.
- R11: The block operates correctly with its clock at 16 times the SCL rate and at slower bus rates. It changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| sda_oe | output | 1 | 1 pulls SDA low; 0 leaves it released |
| host_raddr | input | IDX_W (4) | Word index for the side read port |
| host_rdata | output | 16 | Stored word at host_raddr |
| bus_busy | output | 1 | A transaction is open (between START and STOP) |
| selected | output | 1 | This block was addressed in the current transaction |

## Verification
A wrong bit count or a lost START/STOP edge shows up on the bus within one byte time. The acknowledge arrives in the wrong clock, or the reply bytes come back shifted by one bit. A stale byte counter would only show up one frame later, as a write landing on the wrong word or carrying the wrong value. For that reason, every short or aborted frame in the bench is followed by a complete frame, whose result is checked on the side port. A reply holder that changes when it should not is exposed by the next read phase, which returns the wrong word.

// File: rtl/i2c_wb_pkg.sv
package i2c_wb_pkg;
    localparam int         WORD_W    = 16;
    localparam int         BYTE_W    = 8;
    localparam int         FRAME_LEN = 5;
    localparam int         REPLY_LEN = 3;
    localparam logic [7:0] OP_WRITE  = 8'h00;
    localparam logic [7:0] OP_READ   = 8'h80;
    localparam logic [7:0] FILL_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } tgt_state_e;
endpackage

// File: rtl/i2c_wb_line_sync.sv
module i2c_wb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    typedef struct packed {
        logic [STAGES-1:0] scl_p;
        logic [STAGES-1:0] sda_p;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t s_d, s_q;
    logic  scl_s;

    assign scl_s = s_q.scl_p[STAGES-1];
    assign sda_s = s_q.sda_p[STAGES-1];

    always_comb begin
        s_d          = s_q;
        s_d.scl_p    = {s_q.scl_p[STAGES-2:0], scl_i};
        s_d.sda_p    = {s_q.sda_p[STAGES-2:0], sda_i};
        s_d.scl_prev = scl_s;
        s_d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    // Line events from the settled samples and the previous settled sample
    assign scl_rise = scl_s & ~s_q.scl_prev;
    assign scl_fall = ~scl_s & s_q.scl_prev;
    assign start_ev = scl_s & s_q.scl_prev & s_q.sda_prev & ~sda_s;
    assign stop_ev  = scl_s & s_q.scl_prev & ~s_q.sda_prev & sda_s;
endmodule

// File: rtl/i2c_wb_regfile.sv
module i2c_wb_regfile #(
    parameter  int DEPTH = 16,
    parameter  int WIDTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] raddr_a,
    output logic [WIDTH-1:0] rdata_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [WIDTH-1:0] rdata_b
);
    logic [DEPTH-1:0][WIDTH-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/i2c_wb_target.sv
module i2c_wb_target
    import i2c_wb_pkg::*;
#(
    parameter  logic [6:0] TGT_ADDR = 7'h42,
    parameter  int         DEPTH    = 16,
    localparam int         IDX_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    output logic              sda_oe,
    output logic              busy,
    output logic              sel,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [WORD_W-1:0] rf_wdata,
    output logic [IDX_W-1:0]  rf_raddr,
    input  logic [WORD_W-1:0] rf_rdata
);
    localparam logic [3:0] BITS_DONE = 4'(BYTE_W);
    localparam logic [2:0] RX_LAST   = 3'(FRAME_LEN - 1);
    localparam logic [2:0] RX_SAT    = 3'(FRAME_LEN);
    localparam logic [1:0] TX_SAT    = 2'(REPLY_LEN - 1);

    typedef struct packed {
        tgt_state_e         st;
        logic [3:0]         bitcnt;
        logic [7:0]         shreg;
        logic [7:0]         txsh;
        logic [2:0]         rx_cnt;
        logic [1:0]         tx_cnt;
        logic               rw;
        logic               mack;
        logic [7:0]         op;
        logic [IDX_W-1:0]   widx;
        logic [7:0]         vhi;
        logic [7:0]         vlo;
        logic [WORD_W-1:0]  held;
        logic               sda_oe;
        logic               busy;
        logic               sel;
        logic               we;
        logic [IDX_W-1:0]   waddr;
        logic [WORD_W-1:0]  wdata;
    } tgt_t;

    tgt_t q, d;

    function automatic logic [7:0] reply_byte(input logic [1:0] idx, input logic [WORD_W-1:0] w);
        case (idx)
            2'd0:    reply_byte = w[15:8];
            2'd1:    reply_byte = w[7:0];
            default: reply_byte = FILL_BYTE;
        endcase
    endfunction

    assign rf_raddr = q.widx;

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (stop_ev) begin
            d.st     = ST_IDLE;
            d.sda_oe = 1'b0;
            d.busy   = 1'b0;
            d.sel    = 1'b0;
            d.bitcnt = '0;
            d.rx_cnt = '0;
            d.tx_cnt = '0;
        end else if (start_ev) begin
            d.st     = ST_ADDR;
            d.sda_oe = 1'b0;
            d.busy   = 1'b1;
            d.sel    = 1'b0;
            d.bitcnt = '0;
            d.rx_cnt = '0;
            d.tx_cnt = '0;
        end else begin
            case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.shreg  = {q.shreg[6:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == BITS_DONE) begin
                        if (q.shreg[7:1] == TGT_ADDR) begin
                            d.sel    = 1'b1;
                            d.rw     = q.shreg[0];
                            d.sda_oe = 1'b1;
                            d.st     = ST_ADDR_ACK;
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.bitcnt = '0;
                        if (q.rw) begin
                            d.txsh   = reply_byte(q.tx_cnt, q.held);
                            d.sda_oe = ~d.txsh[7];
                            d.st     = ST_TX;
                        end else begin
                            d.sda_oe = 1'b0;
                            d.st     = ST_RX;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        d.shreg  = {q.shreg[6:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == BITS_DONE) begin
                        d.sda_oe = 1'b1;
                        d.st     = ST_RX_ACK;
                        if (q.rx_cnt != RX_SAT) d.rx_cnt = q.rx_cnt + 3'd1;
                        case (q.rx_cnt)
                            3'd0: d.op   = q.shreg;
                            3'd1: d.widx = q.shreg[IDX_W-1:0];
                            3'd2: d.vhi  = q.shreg;
                            3'd3: d.vlo  = q.shreg;
                            default: ;
                        endcase
                        if (q.rx_cnt == RX_LAST) begin
                            if (q.op == OP_WRITE) begin
                                d.we    = 1'b1;
                                d.waddr = q.widx;
                                d.wdata = {q.vhi, q.vlo};
                            end else if (q.op == OP_READ) begin
                                d.held = rf_rdata;
                            end
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        d.sda_oe = 1'b0;
                        d.bitcnt = '0;
                        d.st     = ST_RX;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bitcnt == BITS_DONE) begin
                            d.sda_oe = 1'b0;
                            d.st     = ST_TX_ACK;
                            if (q.tx_cnt != TX_SAT) d.tx_cnt = q.tx_cnt + 2'd1;
                        end else if (q.bitcnt != 4'd0) begin
                            d.txsh   = {q.txsh[6:0], 1'b0};
                            d.sda_oe = ~d.txsh[7];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        d.bitcnt = '0;
                        if (q.mack) begin
                            d.txsh   = reply_byte(q.tx_cnt, q.held);
                            d.sda_oe = ~d.txsh[7];
                            d.st     = ST_TX;
                        end else begin
                            d.sda_oe = 1'b0;
                            d.st     = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe   = q.sda_oe;
    assign busy     = q.busy;
    assign sel      = q.sel;
    assign rf_we    = q.we;
    assign rf_waddr = q.waddr;
    assign rf_wdata = q.wdata;
endmodule

// File: rtl/i2c_word_bridge.sv
module i2c_word_bridge
    import i2c_wb_pkg::*;
#(
    parameter  logic [6:0] TGT_ADDR    = 7'h42,
    parameter  int         DEPTH       = 16,
    parameter  int         SYNC_STAGES = 2,
    localparam int         IDX_W       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [IDX_W-1:0]  host_raddr,
    output logic [WORD_W-1:0] host_rdata,
    output logic              bus_busy,
    output logic              selected
);
    logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic              rf_we;
    logic [IDX_W-1:0]  rf_waddr, rf_raddr;
    logic [WORD_W-1:0] rf_wdata, rf_rdata;

    i2c_wb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_wb_target #(.TGT_ADDR(TGT_ADDR), .DEPTH(DEPTH)) u_tgt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .sda_oe   (sda_oe),
        .busy     (bus_busy),
        .sel      (selected),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr),
        .rf_wdata (rf_wdata),
        .rf_raddr (rf_raddr),
        .rf_rdata (rf_rdata)
    );

    i2c_wb_regfile #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (rf_raddr),
        .rdata_a (rf_rdata),
        .raddr_b (host_raddr),
        .rdata_b (host_rdata)
    );
endmodule

// File: rtl/i2c_word_bridge_chk.sv
module i2c_word_bridge_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic start_ev,
    input logic stop_ev,
    input logic sda_oe,
    input logic bus_busy,
    input logic selected,
    input logic rf_we
);
    // R2: an open transaction is flagged once START is seen
    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> bus_busy);

    // R2: STOP closes the transaction and frees the line
    a_r2_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (!bus_busy && !sda_oe && !selected));

    // R3: the line is only pulled by a selected target
    a_r3_drive_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> selected);

    // R11: new low drive starts only while SCL is low
    a_r11_drive_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R5: bank writes happen only inside a transaction
    a_r5_write_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> bus_busy);
endmodule

bind i2c_word_bridge i2c_word_bridge_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_oe   (sda_oe),
    .bus_busy (bus_busy),
    .selected (selected),
    .rf_we    (rf_we)
);

// File: tb/tb_i2c_word_bridge.sv
module tb_i2c_word_bridge;
    localparam logic [6:0] TGT = 7'h42;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl_low = 1'b0;
    logic        m_sda_oe = 1'b0;
    logic        sda_oe;
    logic [3:0]  host_raddr = '0;
    logic [15:0] host_rdata;
    logic        bus_busy, selected;
    logic        scl_bus, sda_bus;

    int checks = 0;
    int errors = 0;
    int Q = 8;
    bit done = 1'b0;

    typedef struct {
        string      req;
        logic [7:0] val;
    } item_t;
    item_t exp_q[$];
    logic [7:0] obs_q[$];

    always #2.5 clk = ~clk;

    assign scl_bus = ~m_scl_low;
    assign sda_bus = ~(m_sda_oe | sda_oe);

    i2c_word_bridge dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_bus),
        .sda_i      (sda_bus),
        .sda_oe     (sda_oe),
        .host_raddr (host_raddr),
        .host_rdata (host_rdata),
        .bus_busy   (bus_busy),
        .selected   (selected)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic expect_byte(input string req, input logic [7:0] v);
        item_t it;
        it.req = req;
        it.val = v;
        exp_q.push_back(it);
    endtask

    // Scoreboard monitor: compares reply bytes as the master collects them
    initial begin
        forever begin
            @(posedge clk);
            while (obs_q.size() > 0) begin
                logic [7:0] got;
                item_t      it;
                got = obs_q.pop_front();
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL unexpected reply act=%h exp=none", got);
                end else begin
                    it = exp_q.pop_front();
                    check(it.req, {24'h0, got}, {24'h0, it.val});
                end
            end
        end
    end

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bitx(input logic b, output logic r);
        m_sda_oe = ~b;
        wq(1);
        m_scl_low = 1'b0;
        wq(1);
        r = sda_bus;
        wq(1);
        m_scl_low = 1'b1;
        wq(1);
    endtask

    task automatic bus_start();
        m_sda_oe = 1'b0;
        wq(1);
        m_scl_low = 1'b0;
        wq(2);
        m_sda_oe = 1'b1;
        wq(2);
        m_scl_low = 1'b1;
        wq(1);
    endtask

    task automatic bus_stop();
        m_sda_oe = 1'b1;
        wq(1);
        m_scl_low = 1'b0;
        wq(2);
        m_sda_oe = 1'b0;
        wq(2);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bitx(b[i], r);
        bitx(1'b1, r);
        ack = ~r;
    endtask

    task automatic rd_byte(input logic ack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bitx(1'b1, r);
            b[i] = r;
        end
        bitx(~ack, r);
    endtask

    // Opens a transaction and sends a write-direction address plus n bytes
    task automatic send_bytes(input string req, input logic [6:0] a, input logic [7:0] b0,
                              input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3,
                              input logic [7:0] b4, input int n, input logic exp_ack);
        logic       ack;
        logic [7:0] bs [5];
        bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3; bs[4] = b4;
        bus_start();
        wr_byte({a, 1'b0}, ack);
        check({req, " address ack (R3)"}, {31'h0, ack}, {31'h0, exp_ack});
        for (int i = 0; i < n; i++) begin
            wr_byte(bs[i], ack);
            check({req, " data ack (R4)"}, {31'h0, ack}, {31'h0, exp_ack});
        end
    endtask

    task automatic read_phase(input string req, input logic [15:0] w);
        logic       ack;
        logic [7:0] b;
        expect_byte(req, w[15:8]);
        expect_byte(req, w[7:0]);
        expect_byte(req, 8'hFF);
        bus_start();
        wr_byte({TGT, 1'b1}, ack);
        check({req, " read address ack (R3)"}, {31'h0, ack}, 32'h1);
        rd_byte(1'b1, b); obs_q.push_back(b);
        rd_byte(1'b1, b); obs_q.push_back(b);
        rd_byte(1'b0, b); obs_q.push_back(b);
        bus_stop();
    endtask

    task automatic host_word(input string req, input logic [3:0] idx, input logic [15:0] exp);
        @(negedge clk);
        host_raddr = idx;
        @(negedge clk);
        check(req, {16'h0, host_rdata}, {16'h0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog act=timeout exp=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] b;
        repeat (5) @(negedge clk);
        // R1: reset values
        check("R1 sda_oe", {31'h0, sda_oe}, 32'h0);
        check("R1 bus_busy", {31'h0, bus_busy}, 32'h0);
        check("R1 selected", {31'h0, selected}, 32'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        host_word("R1 word 0", 4'd0, 16'h0000);
        host_word("R1 word 15", 4'd15, 16'h0000);

        // R2: START/STOP tracking
        bus_start();
        check("R2 busy after START", {31'h0, bus_busy}, 32'h1);
        bus_stop();
        wq(1);
        check("R2 idle after STOP", {30'h0, bus_busy, sda_oe}, 32'h0);

        // R5: write 0xBEEF to word 5
        send_bytes("R5 write", TGT, 8'h00, 8'h05, 8'hBE, 8'hEF, 8'h00, 5, 1'b1);
        check("R3 selected", {31'h0, selected}, 32'h1);
        bus_stop();
        host_word("R5 word 5", 4'd5, 16'hBEEF);

        // R6: read word 5 back
        send_bytes("R6 read cmd", TGT, 8'h80, 8'h05, 8'h00, 8'h00, 8'h00, 5, 1'b1);
        read_phase("R6 reply", 16'hBEEF);

        // R8: index 0x13 selects word 3
        send_bytes("R8 write", TGT, 8'h00, 8'h13, 8'h12, 8'h34, 8'h00, 5, 1'b1);
        bus_stop();
        host_word("R8 word 3", 4'd3, 16'h1234);

        // R7: unknown opcode changes nothing, reply keeps old word
        send_bytes("R7 bad op", TGT, 8'h55, 8'h03, 8'hAA, 8'hAA, 8'h00, 5, 1'b1);
        read_phase("R7 reply", 16'hBEEF);
        host_word("R7 word 3", 4'd3, 16'h1234);

        // R3: foreign address is ignored
        send_bytes("R3 foreign", 7'h21, 8'h00, 8'h05, 8'h00, 8'h00, 8'h00, 5, 1'b0);
        check("R3 not selected", {31'h0, selected}, 32'h0);
        bus_stop();
        host_word("R3 word 5 kept", 4'd5, 16'hBEEF);

        // R9: short frame then repeated START, then a full frame
        send_bytes("R9 short", TGT, 8'h00, 8'h07, 8'h11, 8'h00, 8'h00, 3, 1'b1);
        send_bytes("R9 after rstart", TGT, 8'h00, 8'h07, 8'h56, 8'h78, 8'h00, 5, 1'b1);
        bus_stop();
        host_word("R9 word 7", 4'd7, 16'h5678);
        // R9: short frame then STOP, then a full frame
        send_bytes("R9 cut", TGT, 8'h00, 8'h08, 8'h00, 8'h00, 8'h00, 2, 1'b1);
        bus_stop();
        send_bytes("R9 after stop", TGT, 8'h00, 8'h08, 8'h9A, 8'hBC, 8'h00, 5, 1'b1);
        bus_stop();
        host_word("R9 word 8", 4'd8, 16'h9ABC);

        // R10: master NACKs first reply byte; block must go quiet
        send_bytes("R10 read cmd", TGT, 8'h80, 8'h07, 8'h00, 8'h00, 8'h00, 5, 1'b1);
        expect_byte("R10 first byte", 8'h56);
        expect_byte("R10 quiet after NACK", 8'hFF);
        bus_start();
        wr_byte({TGT, 1'b1}, ack);
        check("R10 read address ack", {31'h0, ack}, 32'h1);
        rd_byte(1'b0, b); obs_q.push_back(b);
        rd_byte(1'b0, b); obs_q.push_back(b);
        check("R10 sda released", {31'h0, sda_oe}, 32'h0);
        bus_stop();

        // R11: fastest supported ratio (16x) and a slow bus
        Q = 4;
        send_bytes("R11 fast write", TGT, 8'h00, 8'h09, 8'hC3, 8'h5A, 8'h00, 5, 1'b1);
        bus_stop();
        host_word("R11 fast word 9", 4'd9, 16'hC35A);
        send_bytes("R11 fast read", TGT, 8'h80, 8'h09, 8'h00, 8'h00, 8'h00, 5, 1'b1);
        read_phase("R11 fast reply", 16'hC35A);
        Q = 32;
        send_bytes("R11 slow write", TGT, 8'h00, 8'h0A, 8'h0F, 8'hF0, 8'h00, 5, 1'b1);
        bus_stop();
        send_bytes("R11 slow read", TGT, 8'h80, 8'h0A, 8'h00, 8'h00, 8'h00, 5, 1'b1);
        read_phase("R11 slow reply", 16'h0FF0);

        repeat (20) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule